// File: doc/BRIEF.md
# Optical Amplifier Power Equalization Loop Controller

This block keeps the output power of an on-chip optical amplifier steady while its input power varies. A photodetector drives a current-controlled oscillator whose rate rises with optical power, and the controller receives that oscillator after a divide-by-two stage. The controller counts its rising edges over a fixed gate window. It compares the count with a programmable setpoint and runs a proportional-integral law to pick a 6-bit drive code for the amplifier.

The new code is packed with a fixed code for the second amplifier of the same 2x2 switch element into a 12-bit word. The word is shifted out on a serial data and clock pair, with a programmable clock divider, and then committed by a separate load strobe. The current drivers therefore change only on that strobe. A switch-enable path gates the drivers independently of the loop. The loop repeats back to back while it is enabled. When the loop is disabled, the last committed code stays in place.

Top module: `pwr_eq_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until the loop is enabled, `busy`, `ser_clk`, `ser_load`, `ser_data` and `drv_en` are all 0, and the integrator starts at 0.
- R2: The measured count equals the number of rising edges on `det_pulse` inside a gate of `GATE_CYC` clock cycles that opens on the cycle `busy` rises. Counts up to at least 1200 are exact, and the count saturates at 2^CNT_W-1.
- R3: The error is e = setpoint - count. With F = 8 fraction bits, p = (e*256)>>>kp_shift and ic = I + ((e*256)>>>ki_shift). The value u = ic + p gives the code floor(u/256), where >>> is an arithmetic right shift.
- R4: If u >= 16384 the code is 63, and if u < 0 the code is 0. When the code is clamped high with e > 0, or clamped low with e < 0, I is left unchanged. Otherwise I becomes ic limited to 0..16383.
- R5: Every update is one 12-bit word sent MSB first. Bits 11:6 hold the loop code and bits 5:0 hold `hold_code`. `ser_data` is stable while `ser_clk` is high, so the receiver samples it on the rising edge.
- R6: Each high phase of `ser_clk` lasts `div_half`+2 clock cycles, and so does each low phase. `div_half` is latched at the start of the word.
- R7: After the 12th high phase, `ser_load` goes high for `div_half`+2 cycles, exactly once per word. It rises only on the cycle after `ser_clk` was high.
- R8: `drv_en` equals `sw_en` delayed by one clock, in every state, including during shifting and loading.
- R9: `busy` is high from the start of the gate until the end of the load. When `loop_en` is low in idle, no new loop starts and `ser_clk` and `ser_load` stay low. A loop that is already running completes its word and its load.
- R10: The integrator changes only in the compute step. After a pause of the loop, the next word continues from the integrator value left by the last completed loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_pulse | input | 1 | Divided detector oscillator, asynchronous |
| loop_en | input | 1 | Allows a new measure-compute-update loop to start |
| sw_en | input | 1 | Driver switch enable request |
| setpoint | input | CNT_W | Target edge count per gate |
| kp_shift | input | SH_W | Proportional gain as a right-shift amount |
| ki_shift | input | SH_W | Integral gain as a right-shift amount |
| hold_code | input | 6 | Fixed code for the second amplifier |
| div_half | input | DIV_W | Serial clock phase length minus 2, in clocks |
| ser_data | output | 1 | Serial data, MSB first |
| ser_clk | output | 1 | Serial shift clock |
| ser_load | output | 1 | Load strobe that commits the shifted word |
| drv_en | output | 1 | Registered driver enable |
| busy | output | 1 | High while a loop is in progress |

## Verification
Two functions can fall in the same cycle. First, the switch-enable path can change while the serial word is being shifted or loaded. The bench toggles `sw_en` while `ser_load` is high and expects `drv_en` to follow one cycle later, while the committed word stays bit-exact. Second, the loop can be disabled while a word is in flight. The bench drops `loop_en` after the first serial clock of a word and expects that word to complete with its load, followed by silence. The next enabled loop must then continue from the integrator value that the behavioural model holds.

// File: rtl/pwr_eq_pkg.sv
package pwr_eq_pkg;
  localparam int CODE_W = 6;
  localparam int WORD_W = 2 * CODE_W;
  localparam int FRAC = 8;

  typedef enum logic [2:0] {
    LP_IDLE,
    LP_MEASURE,
    LP_COMPUTE,
    LP_SHIFT,
    LP_LOAD
  } loop_st_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_LO,
    TX_HI,
    TX_LD
  } tx_st_e;
endpackage

// File: rtl/pwr_eq_meas.sv
module pwr_eq_meas #(
  parameter int CNT_W = 11,
  parameter int GATE_CYC = 80000,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_pulse,
  input  logic             start,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  localparam int TMR_W = $clog2(GATE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_N:0]    sync_q;
  logic               edge_seen;
  logic               active_q;
  logic [TMR_W-1:0]   tmr_q;
  logic [CNT_W-1:0]   cnt_q;

  // synchronizer chain plus one delayed stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-1:0], det_pulse};
  end

  assign edge_seen = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
  assign done      = active_q && (tmr_q == '0);
  assign cnt       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tmr_q    <= '0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      tmr_q    <= TMR_W'(GATE_CYC - 1);
      cnt_q    <= '0;
    end else if (active_q) begin
      if (edge_seen && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (tmr_q == '0) active_q <= 1'b0;
      else             tmr_q <= tmr_q - 1'b1;
    end
  end

  // R2: count only moves inside the gate
  a_r2_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/pwr_eq_pi.sv
module pwr_eq_pi
  import pwr_eq_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int SH_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [CNT_W-1:0]  meas,
  input  logic [CNT_W-1:0]  setpoint,
  input  logic [SH_W-1:0]   kp_shift,
  input  logic [SH_W-1:0]   ki_shift,
  output logic [CODE_W-1:0] code
);
  localparam int ACC_W = CNT_W + FRAC + 3;
  localparam int I_W = CODE_W + FRAC;
  localparam logic signed [ACC_W-1:0] U_HI = ACC_W'(1 << I_W);
  localparam logic signed [ACC_W-1:0] I_MAX = ACC_W'((1 << I_W) - 1);

  logic signed [ACC_W-1:0] integ_q, integ_nx;
  logic [CODE_W-1:0]       code_q, code_nx;

  function automatic logic signed [ACC_W-1:0] err_of(
    input logic [CNT_W-1:0] sp, input logic [CNT_W-1:0] m);
    return $signed(ACC_W'(sp)) - $signed(ACC_W'(m));
  endfunction

  // one PI step: returns the new code and the new integrator value
  function automatic void pi_step(
    input  logic signed [ACC_W-1:0] integ,
    input  logic signed [ACC_W-1:0] err,
    input  logic [SH_W-1:0]         kp,
    input  logic [SH_W-1:0]         ki,
    output logic [CODE_W-1:0]       c,
    output logic signed [ACC_W-1:0] inext);
    logic signed [ACC_W-1:0] es, p, ic, u;
    logic hi, lo, freeze;
    es = err <<< FRAC;
    p  = es >>> kp;
    ic = integ + (es >>> ki);
    u  = ic + p;
    hi = (u >= U_HI);
    lo = (u < 0);
    if (hi)      c = '1;
    else if (lo) c = '0;
    else         c = u[FRAC +: CODE_W];
    freeze = (hi && err > 0) || (lo && err < 0);
    if (freeze)         inext = integ;
    else if (ic < 0)    inext = '0;
    else if (ic > I_MAX) inext = I_MAX;
    else                inext = ic;
  endfunction

  always_comb begin
    pi_step(integ_q, err_of(setpoint, meas), kp_shift, ki_shift, code_nx, integ_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      code_q  <= '0;
    end else if (stb) begin
      integ_q <= integ_nx;
      code_q  <= code_nx;
    end
  end

  assign code = code_q;

  // R10: integrator moves only on the compute strobe
  a_r10_integ_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(integ_q));
  // R4: integrator stays inside its range
  a_r4_integ_range: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (integ_q >= 0) && (integ_q <= I_MAX));
endmodule

// File: rtl/pwr_eq_serial.sv
module pwr_eq_serial
  import pwr_eq_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic [DIV_W-1:0]  div_half,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_load,
  output logic              tx_idle,
  output logic              tx_in_load,
  output logic              tx_done
);
  localparam int HALF_W = DIV_W + 1;
  localparam int BIT_W = $clog2(WORD_W);

  tx_st_e            st_q;
  logic [HALF_W-1:0] tmr_q, half_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      tmr_q  <= '0;
      half_q <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      case (st_q)
        TX_IDLE: if (start) begin
          sh_q   <= word;
          bit_q  <= BIT_W'(WORD_W - 1);
          half_q <= HALF_W'(div_half) + HALF_W'(1);
          tmr_q  <= HALF_W'(div_half) + HALF_W'(1);
          st_q   <= TX_LO;
        end
        TX_LO: begin
          if (tmr_q == '0) begin
            st_q  <= TX_HI;
            tmr_q <= half_q;
          end else tmr_q <= tmr_q - 1'b1;
        end
        TX_HI: begin
          if (tmr_q == '0) begin
            tmr_q <= half_q;
            if (bit_q == '0) st_q <= TX_LD;
            else begin
              sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
              bit_q <= bit_q - 1'b1;
              st_q  <= TX_LO;
            end
          end else tmr_q <= tmr_q - 1'b1;
        end
        TX_LD: begin
          if (tmr_q == '0) st_q <= TX_IDLE;
          else             tmr_q <= tmr_q - 1'b1;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign ser_clk    = (st_q == TX_HI);
  assign ser_load   = (st_q == TX_LD);
  assign ser_data   = ((st_q == TX_LO) || (st_q == TX_HI)) && sh_q[WORD_W-1];
  assign tx_idle    = (st_q == TX_IDLE);
  assign tx_in_load = (st_q == TX_LD);
  assign tx_done    = (st_q == TX_LD) && (tmr_q == '0);

  logic [HALF_W:0] hi_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len_q <= '0;
    else if (ser_clk) hi_len_q <= hi_len_q + 1'b1;
    else              hi_len_q <= '0;
  end

  // R5: data does not move while the serial clock is high
  a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
  // R6: each high phase lasts div_half+2 cycles
  a_r6_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (hi_len_q == {1'b0, half_q} + 1'b1));
  // R7: load strobe follows a high clock phase
  a_r7_load_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_load) |-> $past(ser_clk));
endmodule

// File: rtl/pwr_eq_ctrl.sv
module pwr_eq_ctrl
  import pwr_eq_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int GATE_CYC = 80000,
  parameter int SH_W = 4,
  parameter int DIV_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_pulse,
  input  logic              loop_en,
  input  logic              sw_en,
  input  logic [CNT_W-1:0]  setpoint,
  input  logic [SH_W-1:0]   kp_shift,
  input  logic [SH_W-1:0]   ki_shift,
  input  logic [CODE_W-1:0] hold_code,
  input  logic [DIV_W-1:0]  div_half,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_load,
  output logic              drv_en,
  output logic              busy
);
  loop_st_e          st_q, st_d;
  logic              meas_start, meas_done, pi_stb, tx_start;
  logic              tx_idle, tx_in_load, tx_done;
  logic [CNT_W-1:0]  meas_cnt;
  logic [CODE_W-1:0] loop_code;
  logic              drv_en_q;

  always_comb begin
    st_d       = st_q;
    meas_start = 1'b0;
    pi_stb     = 1'b0;
    tx_start   = 1'b0;
    case (st_q)
      LP_IDLE: if (loop_en) begin
        meas_start = 1'b1;
        st_d       = LP_MEASURE;
      end
      LP_MEASURE: if (meas_done) st_d = LP_COMPUTE;
      LP_COMPUTE: begin
        pi_stb = 1'b1;
        st_d   = LP_SHIFT;
      end
      LP_SHIFT: begin
        tx_start = tx_idle;
        if (tx_in_load) st_d = LP_LOAD;
      end
      LP_LOAD: if (tx_done) st_d = LP_IDLE;
      default: st_d = LP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= LP_IDLE;
      drv_en_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      drv_en_q <= sw_en;
    end
  end

  assign busy   = (st_q != LP_IDLE);
  assign drv_en = drv_en_q;

  pwr_eq_meas #(.CNT_W(CNT_W), .GATE_CYC(GATE_CYC), .SYNC_N(SYNC_N)) meas_i (
    .clk(clk), .rst_n(rst_n), .det_pulse(det_pulse), .start(meas_start),
    .cnt(meas_cnt), .done(meas_done));

  pwr_eq_pi #(.CNT_W(CNT_W), .SH_W(SH_W)) pi_i (
    .clk(clk), .rst_n(rst_n), .stb(pi_stb), .meas(meas_cnt), .setpoint(setpoint),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .code(loop_code));

  pwr_eq_serial #(.DIV_W(DIV_W)) ser_i (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .word({loop_code, hold_code}),
    .div_half(div_half), .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load),
    .tx_idle(tx_idle), .tx_in_load(tx_in_load), .tx_done(tx_done));

  // R8: driver enable is the switch request one cycle late
  a_r8_drv_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drv_en == $past(sw_en)));
  // R9: no loop starts while disabled in idle
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !loop_en) |=> !busy);
  // R9: serial lines are quiet outside a loop
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_load));
endmodule

// File: tb/pwr_eq_ctrl_tb_top.sv
module pwr_eq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GATE = 5200;
  localparam int NT = 12;

  logic clk = 1'b0, rst_n = 1'b0, det_pulse = 1'b0, loop_en = 1'b0, sw_en = 1'b0;
  logic [10:0] setpoint = '0;
  logic [3:0]  kp_shift = '0, ki_shift = '0, div_half = '0;
  logic [5:0]  hold_code = '0;
  logic ser_data, ser_clk, ser_load, drv_en, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_eq_ctrl #(.GATE_CYC(GATE)) dut_i (
    .clk(clk), .rst_n(rst_n), .det_pulse(det_pulse), .loop_en(loop_en), .sw_en(sw_en),
    .setpoint(setpoint), .kp_shift(kp_shift), .ki_shift(ki_shift), .hold_code(hold_code),
    .div_half(div_half), .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load),
    .drv_en(drv_en), .busy(busy));

  int checks = 0, errors = 0;
  bit reported = 0;
  int exp_q[$];
  int exp_half = 2;
  int words_done = 0, rises = 0;
  int model_i = 0;
  logic sw_smp = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // behavioural PI step per R3/R4; returns expected 12-bit word
  function automatic int model_word(int sp, int n, int kp, int ki, int hold);
    int e, p, ic, u, code;
    bit hi, lo;
    e = sp - n;
    p = (e * 256) >>> kp;
    ic = model_i + ((e * 256) >>> ki);
    u = ic + p;
    hi = (u >= 16384);
    lo = (u < 0);
    code = hi ? 63 : (lo ? 0 : (u / 256));
    if (!((hi && e > 0) || (lo && e < 0)))
      model_i = (ic < 0) ? 0 : ((ic > 16383) ? 16383 : ic);
    return code * 64 + hold;
  endfunction

  always @(posedge clk) sw_smp <= sw_en;

  // per-cycle monitor
  logic pclk = 0, pload = 0;
  int cap = 0, nbits = 0, hlen = 0, llen = 0;
  bit hl_bad = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(drv_en == sw_smp, "R8 drv_en follows sw_en", drv_en, sw_smp);
      if (!busy && (ser_clk || ser_load)) chk(0, "R9 serial quiet outside loop", 1, 0);
      if (ser_clk && !pclk) begin
        cap = ((cap << 1) | ser_data) & 12'hFFF;
        nbits++; rises++; hlen = 0;
      end
      if (ser_clk) hlen++;
      if (!ser_clk && pclk && hlen != exp_half) hl_bad = 1;
      if (ser_load) llen++;
      if (ser_load && !pload) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected word", cap, -1);
        else begin
          int ew;
          ew = exp_q.pop_front();
          chk(cap == ew, "R3/R4/R5 shifted word", cap, ew);
          chk(nbits == 12, "R5 bit count", nbits, 12);
          chk(!hl_bad, "R6 high phase length", hlen, exp_half);
        end
      end
      if (!ser_load && pload) begin
        chk(llen == exp_half, "R7 load strobe length", llen, exp_half);
        words_done++; nbits = 0; cap = 0; llen = 0; hl_bad = 0;
      end
      pclk = ser_clk; pload = ser_load;
    end
  end

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) det_pulse = 1'b1;
      @(negedge clk);
      @(negedge clk) det_pulse = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wait_busy(logic v);
    do @(negedge clk); while (busy !== v);
  endtask

  int t_sp[NT]   = '{800, 800, 800, 300, 300, 1200, 100, 500, 500, 0, 2047, 700};
  int t_n[NT]    = '{500, 780, 800, 900, 290, 1200, 1, 520, 480, 50, 0, 650};
  int t_kp[NT]   = '{2, 1, 1, 0, 3, 2, 4, 2, 2, 0, 0, 1};
  int t_ki[NT]   = '{3, 2, 2, 1, 4, 2, 4, 5, 5, 0, 3, 1};
  int t_hold[NT] = '{5, 9, 63, 0, 42, 17, 33, 21, 12, 7, 44, 50};
  int t_div[NT]  = '{0, 1, 0, 2, 3, 0, 15, 1, 0, 2, 1, 0};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!busy && !ser_clk && !ser_load && !ser_data && !drv_en, "R1 outputs in reset",
        {busy, ser_clk, ser_load, ser_data, drv_en}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy || ser_clk || ser_load || ser_data)
        chk(0, "R1/R9 idle while loop disabled", {busy, ser_clk, ser_load, ser_data}, 0);
    end
    chk(!busy, "R1 idle after reset", busy, 0);
    loop_en = 1'b1;
    for (int k = 0; k < NT; k++) begin
      wait_busy(1'b1);
      setpoint = 11'(t_sp[k]); kp_shift = 4'(t_kp[k]); ki_shift = 4'(t_ki[k]);
      hold_code = 6'(t_hold[k]); div_half = 4'(t_div[k]);
      exp_half = t_div[k] + 2;
      sw_en = k[0];
      exp_q.push_back(model_word(t_sp[k], t_n[k], t_kp[k], t_ki[k], t_hold[k]));
      if (k == NT - 1) loop_en = 1'b0;
      repeat (3) @(negedge clk);
      pulses(t_n[k]);
      if (k == 5) begin
        // concurrency: switch enable toggles during the load strobe (R8)
        do @(negedge clk); while (!ser_load);
        sw_en = ~sw_en;
      end
      if (k == 7) begin
        int r0, w0;
        do @(negedge clk); while (!ser_clk);
        loop_en = 1'b0;
        w0 = words_done;
        wait_busy(1'b0);
        @(negedge clk);
        chk(words_done == w0 + 1, "R9 in-flight word completes", words_done, w0 + 1);
        r0 = rises;
        for (int i = 0; i < 100; i++) begin
          @(negedge clk);
          if (busy) chk(0, "R9 no loop while disabled", busy, 0);
        end
        chk(rises == r0, "R9 no serial clocks while disabled", rises, r0);
        loop_en = 1'b1;  // next word checks R10 continuity of the integrator
      end else begin
        wait_busy(1'b0);
      end
    end
    repeat (200) @(negedge clk);
    chk(!busy, "R9 stopped after final loop", busy, 0);
    chk(words_done == NT, "R10 word count", words_done, NT);
    chk(exp_q.size() == 0, "R5 all words seen", exp_q.size(), 0);
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!reported) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", words_done, NT);
      report();
      $finish;
    end
  end
endmodule